// File: doc/BRIEF.md
# Load-Aware Request Dispatcher

This block is the single point that decides which processing core handles each incoming request. Several network backends have already stored each request payload in a shared receive buffer of `NODES * SLOTS_PER_NODE` slots. A backend then hands the dispatcher only the slot index. The dispatcher picks one backend per cycle in round-robin order and keeps the accepted indices in one shared pending FIFO. It sends the oldest index to the core that currently carries the least work. Where the payload sits has no bearing on which core processes it.

Each core's load is estimated only as the number of requests handed to that core and not yet reported finished. A core whose count has reached the cap `LOAD_CAP` (default 2; a cap of 1 gives strict single-queue behaviour) is not eligible for new work. A finished request is reported on a per-core completion strobe, which lowers that core's count. Dispatch to a core uses a valid/ready handshake that carries the slot index on a bus shared by all cores.

Top module: `req_dispatcher`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to its idle state: all outstanding counts are zero, the FIFO is empty, no offer is pending, both round-robin pointers point at index 0, and `err_spurious` is 0. Directly after reset, `core_valid` is all zero.
- R2: Among backends with `be_valid` high, at most one sees `be_ready` high in a cycle. That backend is the first valid one found when scanning upward (with wrap-around) from the backend after the last one granted, starting at backend 0 after reset. A grant is given only while `be_valid` is high, and that request enters the FIFO at the edge.
- R3: Requests leave the FIFO in the order they entered it. While the FIFO holds `FIFO_DEPTH` entries, every `be_ready` bit is low, even in a cycle where an entry leaves. An entry pushed in a cycle cannot be offered in that same cycle.
- R4: The committed load of a core is its outstanding count plus one if the pending offer targets it. A new offer goes to an eligible core with the lowest committed load.
- R5: Among eligible cores that share the lowest committed load, the first one found scanning upward (with wrap-around) from the core after the last one offered work wins. The scan starts at core 0 after reset.
- R6: A core is eligible only when its committed load is below `LOAD_CAP`. While no core is eligible, requests stay in the FIFO. No count ever exceeds `LOAD_CAP`.
- R7: An offer drives exactly one `core_valid` bit. It holds that bit and `core_slot` unchanged until the target core's `core_ready` is high at an edge. The outstanding count rises only at that handshake. A new offer can be loaded at the edge where the previous one is accepted, using counts as they stood before that edge.
- R8: A `done_valid` pulse for a core with a nonzero count lowers that count by one at the edge. A handshake and a completion for the same core at the same edge leave the count unchanged. Completions affect selection from the next cycle onward.
- R9: A `done_valid` pulse for a core whose count is zero does not change that count. From the next cycle onward it sets `err_spurious`, which stays high until reset.
- R10: `core_slot` carries the slot index exactly as the granted backend presented it on its field `be_slot[i*SW +: SW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| be_valid | input | NUM_BE | Per-backend request present |
| be_slot | input | NUM_BE*SW | Slot index per backend, backend i in bits i*SW +: SW |
| be_ready | output | NUM_BE | Per-backend grant; request taken at the edge when high with be_valid |
| core_valid | output | NUM_CORES | One-hot offer to a core |
| core_slot | output | SW | Slot index of the pending offer |
| core_ready | input | NUM_CORES | Per-core acceptance of the offer |
| done_valid | input | NUM_CORES | Per-core completion strobe, one request per pulse |
| err_spurious | output | 1 | Sticky flag: a completion arrived for an idle core |

## Verification
The hardest situation to reach from the ports is an offer being accepted by a core at the same edge that core reports a completion. The stimulus must know which core holds the pending offer, and that core must already have work outstanding. The bench reads this from its own reference model: it withholds `core_ready` until an offer is pending, then raises ready and done together for the targeted core. A second hard case is the full FIFO with every core at its cap. The bench reaches it by flooding from all backends while suppressing completions, and then frees a single core to watch the head go to it.

// File: rtl/rqd_pkg.sv
// Package rqd_pkg
// Shared helpers for the request dispatcher. Holds the index-width
// function used to size every pointer, counter and index.
package rqd_pkg;
    // Bits needed to index n items, never less than one.
    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/rqd_rr_arbiter.sv
// Module rqd_rr_arbiter
// Round-robin grant of one requester per cycle. The scan starts at the
// requester after the last winner. Assumes requests are level signals
// that stay high until granted; enable low suppresses every grant.
module rqd_rr_arbiter #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          fire
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] ptr;

    // Find the first active request at or after the pointer.
    always_comb begin
        int j;
        grant     = '0;
        grant_idx = '0;
        fire      = 1'b0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!fire && enable && req[j]) begin
                fire      = 1'b1;
                grant[j]  = 1'b1;
                grant_idx = j[IW-1:0];
            end
        end
    end

    // Move the pointer just past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (fire) ptr <= (grant_idx == LAST) ? '0 : grant_idx + 1'b1;
    end

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    assert_hold_when_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> grant == '0);
endmodule

// File: rtl/rqd_fifo.sv
// Module rqd_fifo
// Synchronous first-in first-out store for slot indices. No bypass from
// push to pop. Assumes the caller never pushes when full or pops when empty.
module rqd_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = rqd_pkg::idx_w(DEPTH);
    localparam int CNTW = rqd_pkg::idx_w(DEPTH + 1);
    localparam logic [AW-1:0] LASTA = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULLC = CNTW'(DEPTH);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CNTW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == FULLC);
    assign dout  = mem[rd_ptr];

    // Write the payload index into storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LASTA) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LASTA) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rqd_core_select.sv
// Module rqd_core_select
// Combinational choice of the least-loaded eligible core. Ties go to the
// first candidate found scanning upward from start. Assumes the loads given
// already include any offer still waiting for acceptance.
module rqd_core_select #(
    parameter int NC  = 8,
    parameter int CW  = 3,
    parameter int LW  = 2,
    parameter int CAP = 2
) (
    input  logic [NC-1:0][LW-1:0] load,
    input  logic [CW-1:0]         start,
    output logic                  pick_valid,
    output logic [CW-1:0]         pick_idx
);
    // Scan in rotation order, keeping strictly lower loads only.
    always_comb begin
        int c;
        logic [LW-1:0] best;
        pick_valid = 1'b0;
        pick_idx   = '0;
        best       = '0;
        for (int k = 0; k < NC; k++) begin
            c = int'(start) + k;
            if (c >= NC) c = c - NC;
            if (int'(load[c]) < CAP && (!pick_valid || load[c] < best)) begin
                pick_valid = 1'b1;
                pick_idx   = c[CW-1:0];
                best       = load[c];
            end
        end
    end
endmodule

// File: rtl/rqd_load_ctr.sv
// Module rqd_load_ctr
// Outstanding-request counter for one core. It rises on an accepted offer
// and falls on a completion. A completion while at zero is flagged and
// ignored. Assumes the caller never accepts an offer at the cap.
module rqd_load_ctr #(
    parameter int LW  = 2,
    parameter int CAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          done,
    output logic [LW-1:0] count,
    output logic          spurious
);
    logic dec;

    assign spurious = done && (count == '0);
    assign dec      = done && (count != '0);

    // Apply the net change of assignment and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else begin
            case ({inc, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= CAP);
    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && done && count != '0) |=> $stable(count));
    assert_done_lowers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && done && count != '0) |=> count == $past(count) - 1'b1);
    assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && done && count == '0) |=> count == '0);
endmodule

// File: rtl/req_dispatcher.sv
// Module req_dispatcher
// Central dispatcher: arbitrates backends into one pending FIFO, then offers
// the head to the least-loaded eligible core over a valid/ready handshake.
// It tracks per-core outstanding work through completion strobes.
// Assumes payloads are already in their slots before a backend reports them.
module req_dispatcher #(
    parameter int NUM_BE         = 4,
    parameter int NUM_CORES      = 8,
    parameter int NODES          = 4,
    parameter int SLOTS_PER_NODE = 16,
    parameter int FIFO_DEPTH     = 8,
    parameter int LOAD_CAP       = 2,
    localparam int SW            = rqd_pkg::idx_w(NODES * SLOTS_PER_NODE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BE-1:0]    be_valid,
    input  logic [NUM_BE*SW-1:0] be_slot,
    output logic [NUM_BE-1:0]    be_ready,
    output logic [NUM_CORES-1:0] core_valid,
    output logic [SW-1:0]        core_slot,
    input  logic [NUM_CORES-1:0] core_ready,
    input  logic [NUM_CORES-1:0] done_valid,
    output logic                 err_spurious
);
    localparam int BW = rqd_pkg::idx_w(NUM_BE);
    localparam int CW = rqd_pkg::idx_w(NUM_CORES);
    localparam int LW = rqd_pkg::idx_w(LOAD_CAP + 1);
    localparam logic [CW-1:0] LASTC = CW'(NUM_CORES - 1);

    logic [BW-1:0] grant_idx;
    logic          push;
    logic          fifo_full;
    logic          fifo_empty;
    logic [SW-1:0] fifo_head;
    logic          load_offer;

    logic          offer_v;
    logic [CW-1:0] offer_core;
    logic [SW-1:0] offer_slot;
    logic [CW-1:0] core_ptr;
    logic          accept;

    logic [NUM_CORES-1:0][LW-1:0] cnt;
    logic [NUM_CORES-1:0][LW-1:0] committed;
    logic [NUM_CORES-1:0]         spurious;
    logic                         pick_valid;
    logic [CW-1:0]                pick_idx;

    rqd_rr_arbiter #(.N(NUM_BE), .IW(BW)) u_arb (
        .clk(clk), .rst_n(rst_n), .enable(!fifo_full), .req(be_valid),
        .grant(be_ready), .grant_idx(grant_idx), .fire(push)
    );

    rqd_fifo #(.W(SW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push),
        .din(be_slot[grant_idx*SW +: SW]), .pop(load_offer),
        .dout(fifo_head), .empty(fifo_empty), .full(fifo_full)
    );

    // Per-core outstanding counters and their committed loads.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        rqd_load_ctr #(.LW(LW), .CAP(LOAD_CAP)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .inc(accept && offer_core == CW'(c)),
            .done(done_valid[c]),
            .count(cnt[c]), .spurious(spurious[c])
        );
        assign committed[c] = cnt[c] + LW'(offer_v && offer_core == CW'(c));
    end

    rqd_core_select #(.NC(NUM_CORES), .CW(CW), .LW(LW), .CAP(LOAD_CAP)) u_sel (
        .load(committed), .start(core_ptr),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    assign accept     = offer_v && core_ready[offer_core];
    assign load_offer = (!offer_v || accept) && !fifo_empty && pick_valid;
    assign core_slot  = offer_slot;

    // Drive the one-hot offer from the registered target.
    always_comb begin
        core_valid = '0;
        if (offer_v) core_valid[offer_core] = 1'b1;
    end

    // Hold or replace the pending offer and move the tie-break pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offer_v    <= 1'b0;
            offer_core <= '0;
            offer_slot <= '0;
            core_ptr   <= '0;
        end else if (load_offer) begin
            offer_v    <= 1'b1;
            offer_core <= pick_idx;
            offer_slot <= fifo_head;
            core_ptr   <= (pick_idx == LASTC) ? '0 : pick_idx + 1'b1;
        end else if (accept) begin
            offer_v <= 1'b0;
        end
    end

    // Latch any completion that arrived for an idle core.
    always_ff @(posedge clk) begin
        if (!rst_n) err_spurious <= 1'b0;
        else        err_spurious <= err_spurious || (|spurious);
    end

    assert_offer_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_valid));
    assert_offer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_v && !accept) |=> ($stable(core_valid) && $stable(core_slot)));
    assert_offer_in_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        offer_v |-> int'(committed[offer_core]) <= LOAD_CAP);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_spurious |=> err_spurious);
    assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|spurious) |=> err_spurious);
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> be_ready == '0);
endmodule

// File: tb/req_dispatcher_test.sv
// Bench for req_dispatcher: a behavioural reference model with a queue and
// integer counters is advanced every clock and compared to the outputs.
module req_dispatcher_test;
    localparam int NB = 4, NC = 8, NODES = 4, SPN = 16, DEPTH = 8, CAP = 2;
    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0]    be_valid = '0;
    logic [NB*SW-1:0] be_slot = '0;
    logic [NB-1:0]    be_ready;
    logic [NC-1:0]    core_valid;
    logic [SW-1:0]    core_slot;
    logic [NC-1:0]    core_ready = '0;
    logic [NC-1:0]    done_valid = '0;
    logic             err_spurious;

    int checks = 0, fails = 0;

    req_dispatcher #(.NUM_BE(NB), .NUM_CORES(NC), .NODES(NODES),
        .SLOTS_PER_NODE(SPN), .FIFO_DEPTH(DEPTH), .LOAD_CAP(CAP)) uut (
        .clk(clk), .rst_n(rst_n), .be_valid(be_valid), .be_slot(be_slot),
        .be_ready(be_ready), .core_valid(core_valid), .core_slot(core_slot),
        .core_ready(core_ready), .done_valid(done_valid),
        .err_spurious(err_spurious)
    );

    always #5 clk = ~clk;

    // Reference model state
    int m_q[$];
    int m_cnt[NC];
    int m_arb = 0, m_cptr = 0, m_oc = 0, m_os = 0;
    bit m_ov = 0, m_err = 0;

    function automatic int exp_grant();
        if (m_q.size() >= DEPTH) return -1;
        for (int k = 0; k < NB; k++)
            if (be_valid[(m_arb + k) % NB]) return (m_arb + k) % NB;
        return -1;
    endfunction

    function automatic int exp_core();
        int best = -1, bl = 0, c, l;
        for (int k = 0; k < NC; k++) begin
            c = (m_cptr + k) % NC;
            l = m_cnt[c] + ((m_ov && m_oc == c) ? 1 : 0);
            if (l < CAP && (best < 0 || l < bl)) begin best = c; bl = l; end
        end
        return best;
    endfunction

    // Advance the model at each rising edge.
    always @(posedge clk) begin
        int g, b;
        bit acc, ld;
        if (!rst_n) begin
            m_q.delete();
            for (int c = 0; c < NC; c++) m_cnt[c] = 0;
            m_arb = 0; m_cptr = 0; m_ov = 0; m_err = 0; m_oc = 0; m_os = 0;
        end else begin
            g = exp_grant();
            b = exp_core();
            acc = m_ov && core_ready[m_oc];
            ld = (!m_ov || acc) && m_q.size() > 0 && b >= 0;
            for (int c = 0; c < NC; c++) begin
                if (acc && m_oc == c) m_cnt[c]++;
                if (done_valid[c]) begin
                    if ((m_cnt[c] - ((acc && m_oc == c) ? 1 : 0)) == 0) m_err = 1;
                    else m_cnt[c]--;
                end
            end
            if (ld) begin
                m_os = m_q.pop_front(); m_ov = 1; m_oc = b; m_cptr = (b + 1) % NC;
            end else if (acc) m_ov = 0;
            if (g >= 0) begin
                m_q.push_back(int'(be_slot[g*SW +: SW]));
                m_arb = (g + 1) % NB;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Compare every cycle, away from the clock edge.
    always begin
        int g;
        logic [NB-1:0] eb;
        logic [NC-1:0] ec;
        @(negedge clk); #3;
        if (rst_n) begin
            g = exp_grant();
            eb = '0; if (g >= 0) eb[g] = 1'b1;
            ec = '0; if (m_ov) ec[m_oc] = 1'b1;
            chk("R2/R3 be_ready", int'(be_ready), int'(eb));
            chk("R4/R5/R6/R7/R8 core_valid", int'(core_valid), int'(ec));
            if (m_ov) chk("R10 core_slot", int'(core_slot), m_os);
            chk("R9 err_spurious", int'(err_spurious), int'(m_err));
        end
    end

    task automatic step(); @(negedge clk); #1; endtask

    int seq = 0;
    task automatic set_slots();
        for (int i = 0; i < NB; i++) be_slot[i*SW +: SW] = SW'((seq * 5 + i * 17) % 64);
        seq++;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..all: actual hung expected finished");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        rst_n = 1'b1;
        step(); #2;
        chk("R1 core_valid after reset", int'(core_valid), 0);
        chk("R1 err after reset", int'(err_spurious), 0);
        chk("R1 be_ready idle", int'(be_ready), 0);

        // R4/R5: single backend, all cores ready, no completions
        core_ready = '1;
        for (int n = 0; n < 6; n++) begin step(); be_valid = 4'b0001; set_slots(); end
        step(); be_valid = '0;
        repeat (4) step();

        // R2/R3/R6: flood from every backend until cores are capped and FIFO full
        for (int n = 0; n < 40; n++) begin step(); be_valid = '1; set_slots(); end
        step(); be_valid = '0;
        step(); #2;
        chk("R3 backpressure when full", int'(be_ready), 0);

        // R8: free one core, head goes there
        step(); done_valid = 8'b0000_1000;
        step(); done_valid = '0;
        repeat (3) step();
        step(); done_valid = 8'b0000_1000;
        step(); done_valid = '0;
        repeat (3) step();

        // Drain everything
        for (int n = 0; n < 80; n++) begin
            step();
            for (int c = 0; c < NC; c++) done_valid[c] = (m_cnt[c] > 0) && ($urandom % 2 == 0);
        end
        step(); done_valid = '0;
        repeat (3) step();

        // R8: same-edge handshake and completion on the targeted core
        core_ready = '0;
        for (int n = 0; n < 30; n++) begin
            step(); be_valid = 4'b0010; set_slots(); done_valid = '0; core_ready = '0;
            if (m_ov && m_cnt[m_oc] > 0) begin
                core_ready[m_oc] = 1'b1;
                done_valid[m_oc] = 1'b1;
            end else if (m_ov) core_ready[m_oc] = 1'b1;
        end
        step(); be_valid = '0; core_ready = '1; done_valid = '0;
        for (int n = 0; n < 60; n++) begin
            step();
            for (int c = 0; c < NC; c++) done_valid[c] = (m_cnt[c] > 0);
        end
        step(); done_valid = '0; core_ready = '0;
        repeat (3) step();

        // R9: completion for an idle core
        step(); #2;
        chk("R9 err low before", int'(err_spurious), 0);
        for (int c = 0; c < NC; c++) if (m_cnt[c] == 0) begin
            done_valid = '0; done_valid[c] = 1'b1; break;
        end
        step(); done_valid = '0; #2;
        chk("R9 err raised", int'(err_spurious), 1);
        repeat (3) step();

        // Random mix of all inputs
        for (int n = 0; n < 5000; n++) begin
            step();
            be_valid = NB'($urandom);
            set_slots();
            core_ready = NC'($urandom) | NC'($urandom);
            done_valid = NC'($urandom) & NC'($urandom) & NC'($urandom);
        end
        step(); be_valid = '0; done_valid = '0;
        repeat (5) step();
        summary();
    end
endmodule